// File: doc/BRIEF.md
# Multi-Slot Slave Address Matcher

This block sits behind the byte shifter of a two-wire serial slave. When the shifter has taken in the first byte after a start condition, it pulses a capture strobe. The matcher then compares the upper seven bits of that byte against one or three programmable 7-bit slave addresses. It records each hit in a sticky per-slot flag and asks the bit engine to acknowledge the byte.

A byte of all zeros is a general call. It raises the flag of every active slot. A mode input picks how many slots are live: only slot 0, or all three. A format input turns matching off entirely for raw-data transfers. The flags stay set until something clears them. Three events clear them: dropping the interface enable, an interface reset request, or a write to the data register. A clear wins over a match in the same cycle. The flags come out as the low bits of a status byte whose other bits are always zero.

Top module: `i2c_addr_match`

## Requirements
- R1: On a capture strobe in addressing format with the interface enabled, flag i (status bit i) is set on the next clock edge when rx_byte[7:1] equals slot i's address. Bit 0 (read/write) is ignored.
- R2: A captured byte of 0x00 is a general call and sets the flag of every active slot. The byte 0x01 is not a general call.
- R3: While free_fmt is 1, a capture changes no flag and raises no acknowledge request.
- R4: With multi_mode = 0, only slot 0 is compared, and status bits 1 and 2 never become 1.
- R5: With multi_mode = 1, all three slots are compared. Slot i's address is taken from slot_addr[7*i+6 : 7*i].
- R6: Flags are sticky: a capture that does not match leaves flags already set unchanged.
- R7: When if_enable is 0 at a clock edge, all flags are 0 after that edge.
- R8: When if_reset_req is 1 at a clock edge, all flags are 0 after that edge.
- R9: When data_wr is 1 at a clock edge, all flags are 0 after that edge.
- R10: A clear event (R7 to R9) at the same edge as a matching capture leaves all flags 0 and no acknowledge request.
- R11: After reset, status_byte is 0x00. Its bits 7..3 are always 0.
- R12: ack_req is high for exactly the one cycle that follows a capture matching at least one active slot, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_stb | input | 1 | One-cycle strobe: rx_byte holds the first byte after start |
| rx_byte | input | 8 | Captured address byte; bits 7..1 are the address, bit 0 is read/write |
| slot_addr | input | 21 | Three 7-bit slave addresses, slot i at bits 7*i+6..7*i |
| multi_mode | input | 1 | 0: slot 0 only, 1: all three slots |
| free_fmt | input | 1 | 1: free-data format, matching disabled |
| if_enable | input | 1 | Interface enable; 0 clears the flags |
| if_reset_req | input | 1 | Interface reset request; 1 clears the flags |
| data_wr | input | 1 | Data register write event; 1 clears the flags |
| status_byte | output | 8 | Bits 2..0 are the match flags of slots 2..0; bits 7..3 are zero |
| ack_req | output | 1 | Acknowledge request, one cycle after a matching capture |

## Verification
A wrong flag register shows up on status_byte at the first edge after the capture or clear that should have moved it. The bench compares every clock, so such an error is caught one cycle after the stimulus. A wrong mode or format gate shows up as a flag bit appearing where the mode forbids it. A broken clear priority leaves a bit standing after a same-cycle clear and match. Either error is also visible within a single cycle. An acknowledge fault shows as a pulse that comes at the wrong time or lasts the wrong length, and is checked in the cycle right after each capture.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned SLOTS    = 3;
  localparam int unsigned STATUS_W = 8;
endpackage

// File: rtl/addr_match_rst_sync.sv
module addr_match_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/addr_slot_cmp.sv
module addr_slot_cmp #(
  parameter int unsigned ADDR_W = addr_match_pkg::ADDR_W
) (
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              active,
  output logic              hit
);
  logic addr_eq;
  logic gen_call;

  always_comb begin
    addr_eq  = (rx_byte[ADDR_W:1] == slot_addr);
    gen_call = (rx_byte == '0);
    hit      = active && (addr_eq || gen_call);
  end
endmodule

// File: rtl/addr_flag_bank.sv
module addr_flag_bank #(
  parameter int unsigned SLOTS = addr_match_pkg::SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_ok,
  input  logic [SLOTS-1:0] hit,
  output logic [SLOTS-1:0] flags,
  output logic             ack
);
  logic [SLOTS-1:0] flags_d;
  logic             ack_d;
  logic             any_hit;

  always_comb begin
    any_hit = cap_ok && (hit != '0);
    flags_d = flags;
    ack_d   = 1'b0;
    if (clear) begin
      flags_d = '0;
    end else if (cap_ok) begin
      flags_d = flags | hit;
      ack_d   = any_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ack   <= 1'b0;
    end else begin
      flags <= flags_d;
      ack   <= ack_d;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned ADDR_W   = addr_match_pkg::ADDR_W,
  parameter int unsigned SLOTS    = addr_match_pkg::SLOTS,
  parameter int unsigned STATUS_W = addr_match_pkg::STATUS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_stb,
  input  logic [ADDR_W:0]         rx_byte,
  input  logic [SLOTS*ADDR_W-1:0] slot_addr,
  input  logic                    multi_mode,
  input  logic                    free_fmt,
  input  logic                    if_enable,
  input  logic                    if_reset_req,
  input  logic                    data_wr,
  output logic [STATUS_W-1:0]     status_byte,
  output logic                    ack_req
);
  localparam int unsigned PAD_W = STATUS_W - SLOTS;

  logic             rst_q;
  logic             clear;
  logic             cap_ok;
  logic [SLOTS-1:0] slot_act;
  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] flags;

  addr_match_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  always_comb begin
    clear  = !if_enable || if_reset_req || data_wr;
    cap_ok = cap_stb && !free_fmt && if_enable;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_base
      assign slot_act[i] = 1'b1;
    end else begin : g_ext
      assign slot_act[i] = multi_mode;
    end

    addr_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .rx_byte   (rx_byte),
      .slot_addr (slot_addr[i*ADDR_W +: ADDR_W]),
      .active    (slot_act[i]),
      .hit       (hit[i])
    );
  end

  addr_flag_bank #(.SLOTS(SLOTS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_q),
    .clear  (clear),
    .cap_ok (cap_ok),
    .hit    (hit),
    .flags  (flags),
    .ack    (ack_req)
  );

  assign status_byte = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/addr_match_checker.sv
module addr_match_checker #(
  parameter int unsigned ADDR_W   = addr_match_pkg::ADDR_W,
  parameter int unsigned SLOTS    = addr_match_pkg::SLOTS,
  parameter int unsigned STATUS_W = addr_match_pkg::STATUS_W
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic                    cap_stb,
  input logic [ADDR_W:0]         rx_byte,
  input logic [SLOTS*ADDR_W-1:0] slot_addr,
  input logic                    multi_mode,
  input logic                    free_fmt,
  input logic                    if_enable,
  input logic                    if_reset_req,
  input logic                    data_wr,
  input logic [STATUS_W-1:0]     status_byte,
  input logic                    ack_req
);
  logic quiet;
  assign quiet = if_enable && !if_reset_req && !data_wr;

  assert_slot0_hit_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (cap_stb && quiet && !free_fmt && rx_byte[ADDR_W:1] == slot_addr[ADDR_W-1:0])
    |=> (status_byte[0] && ack_req));

  assert_free_fmt_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (quiet && free_fmt) |=> ($stable(status_byte) && !ack_req));

  assert_single_mode_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (quiet && !multi_mode) |=> $stable(status_byte[SLOTS-1:1]));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_q)
    quiet |=> ((status_byte & $past(status_byte)) == $past(status_byte)));

  assert_enable_clear_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !if_enable |=> (status_byte == '0));

  assert_reset_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_q)
    if_reset_req |=> (status_byte == '0));

  assert_data_wr_clear_R9: assert property (@(posedge clk) disable iff (!rst_q)
    data_wr |=> (status_byte == '0 && !ack_req));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_q)
    status_byte[STATUS_W-1:SLOTS] == '0);

  assert_ack_source_R12: assert property (@(posedge clk) disable iff (!rst_q)
    !cap_stb |=> !ack_req);
endmodule

bind i2c_addr_match addr_match_checker #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .STATUS_W(STATUS_W)
) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .cap_stb      (cap_stb),
  .rx_byte      (rx_byte),
  .slot_addr    (slot_addr),
  .multi_mode   (multi_mode),
  .free_fmt     (free_fmt),
  .if_enable    (if_enable),
  .if_reset_req (if_reset_req),
  .data_wr      (data_wr),
  .status_byte  (status_byte),
  .ack_req      (ack_req)
);

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic        clk;
  logic        rst_n;
  logic        cap_stb;
  logic [7:0]  rx_byte;
  logic [20:0] slot_addr;
  logic        multi_mode, free_fmt, if_enable, if_reset_req, data_wr;
  logic [7:0]  status_byte;
  logic        ack_req;

  int    n_run  = 0;
  int    n_fail = 0;
  string tag    = "R11";
  bit    cmp_on = 0;

  logic [2:0] m_flags;
  logic       m_ack;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .rx_byte(rx_byte),
    .slot_addr(slot_addr), .multi_mode(multi_mode), .free_fmt(free_fmt),
    .if_enable(if_enable), .if_reset_req(if_reset_req), .data_wr(data_wr),
    .status_byte(status_byte), .ack_req(ack_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: flags as a small integer set, updated per edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 3'b000;
      m_ack   = 1'b0;
    end else if (!if_enable || if_reset_req || data_wr) begin
      m_flags = 3'b000;
      m_ack   = 1'b0;
    end else begin
      m_ack = 1'b0;
      if (cap_stb && !free_fmt) begin
        for (int s = 0; s < 3; s++) begin
          if ((s == 0 || multi_mode) &&
              (rx_byte == 8'h00 || int'(rx_byte >> 1) == int'((slot_addr >> (7*s)) & 21'h7f))) begin
            m_flags[s] = 1'b1;
            m_ack = 1'b1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_run++;
      if (status_byte !== {5'b0, m_flags} || ack_req !== m_ack) begin
        n_fail++;
        $display("FAIL %s: status=%h ack=%b expected status=%h ack=%b",
                 tag, status_byte, ack_req, {5'b0, m_flags}, m_ack);
      end
    end
  end

  task automatic chk(string req, logic [7:0] got_s, logic got_a,
                     logic [7:0] exp_s, logic exp_a);
    n_run++;
    if (got_s !== exp_s || got_a !== exp_a) begin
      n_fail++;
      $display("FAIL %s: status=%h ack=%b expected status=%h ack=%b",
               req, got_s, got_a, exp_s, exp_a);
    end
  endtask

  // drive a capture; check one cycle later (after the capturing edge)
  task automatic capture(string req, logic [7:0] b, logic [7:0] exp_s, logic exp_a);
    tag = req;
    cap_stb = 1'b1; rx_byte = b;
    @(negedge clk);
    chk(req, status_byte, ack_req, exp_s, exp_a);
    #1 cap_stb = 1'b0;
  endtask

  task automatic pulse_clear(string req, int which, logic [7:0] exp_s);
    tag = req;
    if (which == 0) if_enable = 1'b0;
    if (which == 1) if_reset_req = 1'b1;
    if (which == 2) data_wr = 1'b1;
    @(negedge clk);
    chk(req, status_byte, ack_req, exp_s, 1'b0);
    #1 if_enable = 1'b1; if_reset_req = 1'b0; data_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_stb = 1'b0; rx_byte = 8'h00;
    slot_addr = {7'h7F, 7'h2A, 7'h50};
    multi_mode = 1'b0; free_fmt = 1'b0; if_enable = 1'b0;
    if_reset_req = 1'b0; data_wr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R11", status_byte, ack_req, 8'h00, 1'b0);
    cmp_on = 1;
    if_enable = 1'b1;
    idle(1);

    capture("R1", 8'hA1, 8'h01, 1'b1);        // R/W = 1 still matches
    tag = "R12"; @(negedge clk);
    chk("R12", status_byte, ack_req, 8'h01, 1'b0);
    #1;
    capture("R4", 8'h54, 8'h01, 1'b0);        // slot 1 inactive in single mode
    capture("R4", 8'hFE, 8'h01, 1'b0);        // slot 2 inactive in single mode
    pulse_clear("R9", 2, 8'h00);
    capture("R2", 8'h00, 8'h01, 1'b1);        // general call, single mode
    pulse_clear("R8", 1, 8'h00);

    multi_mode = 1'b1;
    capture("R5", 8'hFE, 8'h04, 1'b1);
    capture("R6", 8'h55, 8'h06, 1'b1);
    capture("R6", 8'h33, 8'h06, 1'b0);
    idle(2);
    chk("R6", status_byte, ack_req, 8'h06, 1'b0);
    pulse_clear("R7", 0, 8'h00);
    capture("R2", 8'h01, 8'h00, 1'b0);        // 0x01 is not a general call
    capture("R2", 8'h00, 8'h07, 1'b1);
    pulse_clear("R9", 2, 8'h00);

    free_fmt = 1'b1;
    capture("R3", 8'hA0, 8'h00, 1'b0);
    capture("R3", 8'h00, 8'h00, 1'b0);
    free_fmt = 1'b0;

    data_wr = 1'b1;
    capture("R10", 8'hA0, 8'h00, 1'b0);
    data_wr = 1'b0;
    if_reset_req = 1'b1;
    capture("R10", 8'h00, 8'h00, 1'b0);
    if_reset_req = 1'b0;
    if_enable = 1'b0;
    capture("R10", 8'h54, 8'h00, 1'b0);
    if_enable = 1'b1;

    capture("R1", 8'hA0, 8'h01, 1'b1);
    capture("R1", 8'h54, 8'h03, 1'b1);
    chk("R11", status_byte & 8'hF8, 1'b0, 8'h00, 1'b0);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule